// File: doc/BRIEF.md
# Slave Port Busy-Input Write Gate

This block is the write-control front end of one memory port on a slave device in a width-expanded dual-port memory. The slave has no arbiter of its own. A single arbiter on the master device settles contention for every chip in the group and drives an active-low busy line to each slave. The slave uses that line only to qualify its own array write strobe. Because there is one arbiter for the group, two chips can never reach opposite decisions: one chip blocking the left port while another blocks the right port would leave both processors waiting forever.

A write request is the port being selected with the strobe set to write. The gate holds the request off for a parameterised number of clock cycles, `ARB_CYC`, which stands for the master's worst-case arbitration time. After that wait it issues a single-cycle array write in the first cycle in which busy is released and the request is still present. If busy is still asserted when the wait ends, the write waits for the release, so the requester keeps its strobe active until the write is done. Reads are not gated. Address and data pass straight through to the array.

Top module: `slv_wr_gate`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `mem_we` is 0.
- R2: `mem_we` is 1 only in a cycle in which a write request is present, where a write request means `port_en` = 1 and `wr_not_rd` = 1.
- R3: Number the cycles of an unbroken write request from 0, starting at its first cycle. `mem_we` is 0 in every cycle whose number is below `ARB_CYC` (default 2).
- R4: `mem_we` is 0 in every cycle in which `busy_n` = 0.
- R5: Once the wait of R3 is over, `mem_we` is 1 in the first cycle in which `busy_n` = 1, provided the request is unbroken. This holds even when busy was 0 in the cycle where the wait ended.
- R6: `mem_we` is 1 in at most one cycle per unbroken request. After the request drops, a new request restarts the count of R3.
- R7: `mem_addr` and `mem_wdata` equal `addr` and `wdata` in the same cycle.
- R8: `mem_re` = 1 exactly when `port_en` = 1 and `wr_not_rd` = 0. It is never delayed or blocked by `busy_n`.
- R9: A request that drops before it has been granted under R5 produces no `mem_we` at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port select, active high |
| wr_not_rd | input | 1 | 1 = write, 0 = read |
| busy_n | input | 1 | Busy from the master arbiter, 0 = inhibited |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| mem_we | output | 1 | Qualified array write strobe, one cycle per request |
| mem_re | output | 1 | Array read enable |
| mem_addr | output | ADDR_W | Address to the array |
| mem_wdata | output | DATA_W | Data to the array |

## Verification
The bench targets the cycle in which the wait ends. A gate with an off-by-one count would write one cycle early or one cycle late. The bench also holds busy low across the end of the wait and then releases it. A design that samples busy only once would lose that write, and one that ignores busy would write while inhibited. After a write it toggles busy while the request stays up, and it drops a request in the middle of the wait. These cases expose a design that writes twice for one request, or one that keeps a stale grant into the next request. Reads are issued while busy is held low, which catches a design that wrongly gates or delays them.

// File: rtl/slv_wr_gate_pkg.sv
package slv_wr_gate_pkg;
   // Width of a counter that must reach the value n.
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/slv_arb_wait.sv
module slv_arb_wait #(
   parameter int unsigned ARB_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic expired
);
   import slv_wr_gate_pkg::*;
   localparam int unsigned CW = cnt_w(ARB_CYC);

   generate
      if (ARB_CYC == 0) begin : g_nowait
         assign expired = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt <= '0;
            else if (!req)                     cnt <= '0;
            else if (cnt != CW'(ARB_CYC))      cnt <= cnt + 1'b1;
         end
         assign expired = (cnt == CW'(ARB_CYC));

         // R3: the wait is never over in the first cycle of a request
         a_r3_not_expired_at_start: assert property (@(posedge clk) disable iff (!rst_n)
            !req |=> !expired);
      end
   endgenerate
endmodule

// File: rtl/slv_wr_issue.sv
module slv_wr_issue (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic expired,
   input  logic busy_n,
   output logic fire
);
   logic done;

   assign fire = req & expired & busy_n & ~done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      done <= 1'b0;
      else if (!req)   done <= 1'b0;
      else if (fire)   done <= 1'b1;
   end

   // R6: a strobe is never followed by a second one in the next cycle
   a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
   // R4: no strobe while the master inhibits the port
   a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> busy_n);
endmodule

// File: rtl/slv_wr_gate.sv
module slv_wr_gate #(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ARB_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              wr_not_rd,
   input  logic              busy_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              mem_we,
   output logic              mem_re,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   import slv_wr_gate_pkg::*;
   localparam int unsigned AW = cnt_w(ARB_CYC) + 1;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("slv_wr_gate: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > 1024) begin : g_bad_data
         $error("slv_wr_gate: DATA_W out of range");
      end
      if (ARB_CYC > 1000) begin : g_bad_arb
         $error("slv_wr_gate: ARB_CYC too large");
      end
   endgenerate

   logic wr_req;
   logic expired;
   logic fire;

   assign wr_req = port_en & wr_not_rd;

   slv_arb_wait #(.ARB_CYC(ARB_CYC)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (wr_req),
      .expired (expired)
   );

   slv_wr_issue u_issue (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (wr_req),
      .expired (expired),
      .busy_n  (busy_n),
      .fire    (fire)
   );

   assign mem_we    = fire;
   assign mem_re    = port_en & ~wr_not_rd;
   assign mem_addr  = addr;
   assign mem_wdata = wdata;

   // Checker-side age of the current request, saturating
   logic [AW-1:0] chk_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               chk_age <= '0;
      else if (!wr_req)                         chk_age <= '0;
      else if (chk_age < AW'(ARB_CYC))          chk_age <= chk_age + 1'b1;
   end

   // R2: strobe only during a write request
   a_r2_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (port_en && wr_not_rd));
   // R3: strobe never before the arbitration wait is over
   a_r3_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (chk_age >= AW'(ARB_CYC)));
   // R8: reads and writes never enabled together
   a_r8_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   // R1: quiet straight after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !mem_we);
endmodule

// File: tb/slv_wr_gate_test.sv
`timescale 1ns/1ps
module slv_wr_gate_test;
   localparam int ADDR_W = 10;
   localparam int DATA_W = 8;
   localparam int ARB    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic port_en = 1'b0, wr_not_rd = 1'b0, busy_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic mem_we, mem_re;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata;

   int checks = 0, errors = 0;
   int age = 0;
   bit done = 1'b0;
   bit fin = 1'b0;
   int writes = 0;

   always #2 clk = ~clk;

   slv_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARB_CYC(ARB)) uut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_not_rd(wr_not_rd),
      .busy_n(busy_n), .addr(addr), .wdata(wdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference, compared every cycle away from the clock edge
   always @(negedge clk) begin
      bit req, exp_we;
      string tag;
      if (!rst_n) begin
         chk("R1 reset mem_we", mem_we, 0);
         age = 0; done = 0;
      end else begin
         req = port_en && wr_not_rd;
         exp_we = req && (age >= ARB) && busy_n && !done;
         if (!req)            tag = "R2/R9 no request";
         else if (age < ARB)  tag = "R3 wait";
         else if (!busy_n)    tag = "R4 busy";
         else if (done)       tag = "R6 once";
         else                 tag = "R5 grant";
         chk(tag, mem_we, exp_we);
         chk("R8 mem_re", mem_re, port_en && !wr_not_rd);
         chk("R7 mem_addr", mem_addr, addr);
         chk("R7 mem_wdata", mem_wdata, wdata);
         if (mem_we) writes++;
         if (req) begin
            if (exp_we) done = 1;
            age++;
         end else begin
            age = 0; done = 0;
         end
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic drive(input bit en, input bit wr, input bit bn, input int a, input int d);
      port_en = en; wr_not_rd = wr; busy_n = bn;
      addr = ADDR_W'(a); wdata = DATA_W'(d);
   endtask

   initial begin
      int w0;
      step(3);
      rst_n = 1'b1;                     // R1 checked during and after reset
      step(2);
      // R8: reads with busy low, no delay
      drive(1, 0, 0, 12, 0); step(3);
      drive(0, 0, 1, 0, 0);  step(1);
      // R3/R5: plain write, strobe on cycle ARB
      w0 = writes;
      drive(1, 1, 1, 'h3FF, 'hA5); step(5);
      chk("R6 one write per request", writes - w0, 1);
      drive(0, 0, 1, 0, 0); step(1);
      // R5/R4: busy low across end of wait, then released
      w0 = writes;
      drive(1, 1, 0, 'h3FE, 'h5A); step(4);
      busy_n = 1'b1; step(1);
      busy_n = 1'b0; step(1);            // R6: toggling after grant
      busy_n = 1'b1; step(2);
      chk("R5 late grant single write", writes - w0, 1);
      drive(0, 0, 1, 0, 0); step(1);
      // R9: request dropped during wait
      w0 = writes;
      drive(1, 1, 1, 7, 1); step(1);
      drive(0, 1, 1, 7, 1); step(1);
      drive(1, 1, 0, 8, 2); step(2);
      drive(1, 0, 1, 8, 2); step(2);     // turned into a read before grant
      chk("R9 withdrawn no write", writes - w0, 0);
      // R6: back-to-back requests with one idle cycle restart the count
      w0 = writes;
      drive(1, 1, 1, 20, 3); step(3);
      drive(0, 1, 1, 20, 3); step(1);
      drive(1, 1, 1, 21, 4); step(4);
      chk("R6 two requests two writes", writes - w0, 2);
      drive(0, 0, 1, 0, 0); step(3);
      fin = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!fin && cyc < 5000) begin
         @(posedge clk); cyc++;
      end
      if (!fin) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      end
      @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule